// File: doc/BRIEF.md
# Planar Colour Expansion Write Path

This block forms the bytes that a CPU write deposits into a four-plane video memory. For every accepted CPU byte write it produces one byte per plane and one byte of bit enables per plane. A two-bit mode field picks where the new plane data comes from. Mode 0 copies the CPU byte into every plane. Mode 1 turns a monochrome byte into colour: each bit picks either the foreground or the background colour, one colour bit per plane. Mode 2 writes a dither pattern held in four foreground latches. Mode 3 writes back the read latches, which gives a transparent copy.

A masked-write stage sits after the mode selection and limits which bit positions are updated. The mask comes either from a mask register or from the CPU byte itself. Bit positions that the mask leaves out are filled with the old plane contents, so the memory can be written through a plain full-width port, or through a port with bit enables. The path has one register stage. Every control input is sampled in the cycle the write strobe is high.

Top module: `colour_expand_wr`

## Requirements
- R1: While reset is asserted and after it is released, `outValid` is 0 and `planeData` and `planeBitEn` are all zero until the first write.
- R2: A write strobe in cycle N gives `outValid` high in cycle N+1 only, with that write's result. A cycle without a strobe gives `outValid` low in the next cycle.
- R3: With `fbMode` = 0, every plane byte equals the CPU byte.
- R4: With `fbMode` = 1, for each plane n and bit position b, the output bit is `fgColour[n]` when pattern bit b is 1 and `bgColour[n]` when it is 0.
- R5: In mode 1 the pattern is `cpuByte` when `srcIsCpu` = 1 and `patternReg` when `srcIsCpu` = 0.
- R6: With `fbMode` = 2, plane n receives foreground latch byte n, which is `fgLatch[8n+7:8n]`. The CPU byte is ignored.
- R7: With `fbMode` = 3, plane n receives read latch byte n, which is `readLatch[8n+7:8n]`, unchanged.
- R8: With `maskEnable` = 0, every bit of `planeBitEn` is 1 for a write.
- R9: With `maskEnable` = 1, each plane's enable byte equals `maskReg` when `maskFromCpu` = 0, and equals `cpuByte` when `maskFromCpu` = 1.
- R10: For every bit whose enable is 0, the `planeData` bit equals the matching bit of `oldPlane` sampled with the write. Plane n occupies bits [8n+7:8n] of all four-plane buses.
- R11: Between writes, `planeData` and `planeBitEn` hold their last values, whatever the control and data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| wrValid | input | 1 | CPU byte write strobe |
| cpuByte | input | 8 | CPU write data |
| fbMode | input | 2 | Write mode: 0 passthrough, 1 solid expansion, 2 dithered foreground, 3 background latch |
| srcIsCpu | input | 1 | Expansion pattern taken from the CPU byte (1) or from patternReg (0) |
| patternReg | input | 8 | Expansion pattern register |
| fgColour | input | 4 | Foreground colour, bit n goes to plane n |
| bgColour | input | 4 | Background colour, bit n goes to plane n |
| maskEnable | input | 1 | Turns on masked writes |
| maskFromCpu | input | 1 | Mask taken from the CPU byte (1) or from maskReg (0) |
| maskReg | input | 8 | Write mask register |
| fgLatch | input | 32 | Four foreground latch bytes |
| readLatch | input | 32 | Four read latch bytes |
| oldPlane | input | 32 | Current contents of the four addressed plane bytes |
| outValid | output | 1 | Result valid |
| planeData | output | 32 | Four plane bytes to write |
| planeBitEn | output | 32 | Per-plane bit enables |

## Verification
The assertions check on every cycle the one-cycle valid timing and the holding of outputs between writes. They also check that bits left out by the mask carry the old plane data, that an unmasked write enables every bit, and that dither mode copies the foreground latches. The bit-level colour expansion, the choice of pattern source and the choice of mask source are shown only by the bench's scenarios. The same holds for passthrough and latch-copy data under mixed back-to-back writes: the bench compares each result against a model built from the requirements.

// File: rtl/pwf_pkg.sv
package pwf_pkg;
  localparam int NUM_PLANES = 4;
  localparam int PLANE_W    = 8;

  typedef enum logic [1:0] {
    MODE_PASS    = 2'd0,
    MODE_SOLID   = 2'd1,
    MODE_DITHER  = 2'd2,
    MODE_BGLATCH = 2'd3
  } fbMode_e;

  typedef struct packed {
    logic load;
    logic selPass;
    logic selSolid;
    logic selDither;
    logic selBgLatch;
    logic useMask;
  } ctrlStrobes_t;
endpackage

// File: rtl/pwf_ctrl.sv
module pwf_ctrl
  import pwf_pkg::*;
#(
  parameter int PLANE_W = pwf_pkg::PLANE_W
) (
  input  logic               wrValid,
  input  logic [1:0]         fbMode,
  input  logic               srcIsCpu,
  input  logic [PLANE_W-1:0] cpuByte,
  input  logic [PLANE_W-1:0] patternReg,
  input  logic               maskEnable,
  input  logic               maskFromCpu,
  input  logic [PLANE_W-1:0] maskReg,
  output ctrlStrobes_t       strobes,
  output logic [PLANE_W-1:0] pattern,
  output logic [PLANE_W-1:0] bitMask
);
  fbMode_e modeSel;

  always_comb begin
    modeSel = fbMode_e'(fbMode);
    strobes = '0;
    strobes.load    = wrValid;
    strobes.useMask = maskEnable;
    unique case (modeSel)
      MODE_PASS:    strobes.selPass    = 1'b1;
      MODE_SOLID:   strobes.selSolid   = 1'b1;
      MODE_DITHER:  strobes.selDither  = 1'b1;
      MODE_BGLATCH: strobes.selBgLatch = 1'b1;
      default:      strobes.selPass    = 1'b1;
    endcase
    pattern = srcIsCpu    ? cpuByte : patternReg;
    bitMask = maskFromCpu ? cpuByte : maskReg;
  end
endmodule

// File: rtl/pwf_datapath.sv
module pwf_datapath
  import pwf_pkg::*;
#(
  parameter int NUM_PLANES = pwf_pkg::NUM_PLANES,
  parameter int PLANE_W    = pwf_pkg::PLANE_W,
  localparam int BUS_W     = NUM_PLANES * PLANE_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic [PLANE_W-1:0]    cpuByte,
  input  logic [PLANE_W-1:0]    pattern,
  input  logic [PLANE_W-1:0]    bitMask,
  input  logic [NUM_PLANES-1:0] fgColour,
  input  logic [NUM_PLANES-1:0] bgColour,
  input  logic [BUS_W-1:0]      fgLatch,
  input  logic [BUS_W-1:0]      readLatch,
  input  logic [BUS_W-1:0]      oldPlane,
  output logic                  outValid,
  output logic [BUS_W-1:0]      planeData,
  output logic [BUS_W-1:0]      planeBitEn
);
  logic [PLANE_W-1:0] enByte;
  logic [BUS_W-1:0]   nextData;
  logic [BUS_W-1:0]   nextEn;

  assign enByte = strobes.useMask ? bitMask : {PLANE_W{1'b1}};

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    logic [PLANE_W-1:0] solidByte;
    logic [PLANE_W-1:0] newByte;
    logic [PLANE_W-1:0] oldByte;

    assign oldByte   = oldPlane[p*PLANE_W +: PLANE_W];
    assign solidByte = (pattern & {PLANE_W{fgColour[p]}}) |
                       (~pattern & {PLANE_W{bgColour[p]}});

    always_comb begin
      newByte = cpuByte;
      if (strobes.selSolid)   newByte = solidByte;
      if (strobes.selDither)  newByte = fgLatch[p*PLANE_W +: PLANE_W];
      if (strobes.selBgLatch) newByte = readLatch[p*PLANE_W +: PLANE_W];
    end

    assign nextData[p*PLANE_W +: PLANE_W] = (newByte & enByte) | (oldByte & ~enByte);
    assign nextEn[p*PLANE_W +: PLANE_W]   = enByte;

    AST_OLD_BITS_KEPT: assert property (@(posedge clk) disable iff (!rstN)
      outValid |-> (((planeData[p*PLANE_W +: PLANE_W] ^ $past(oldPlane[p*PLANE_W +: PLANE_W]))
                    & ~planeBitEn[p*PLANE_W +: PLANE_W]) == '0)); // R10
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      planeData  <= '0;
      planeBitEn <= '0;
    end else begin
      outValid <= strobes.load;
      if (strobes.load) begin
        planeData  <= nextData;
        planeBitEn <= nextEn;
      end
    end
  end

  AST_VALID_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> outValid); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> !outValid); // R2
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(planeData) && $stable(planeBitEn))); // R11
  AST_UNMASKED_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !strobes.useMask) |=> (&planeBitEn)); // R8
  AST_DITHER_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.selDither && !strobes.useMask) |=> (planeData == $past(fgLatch))); // R6
endmodule

// File: rtl/colour_expand_wr.sv
module colour_expand_wr
  import pwf_pkg::*;
#(
  parameter int NUM_PLANES = pwf_pkg::NUM_PLANES,
  parameter int PLANE_W    = pwf_pkg::PLANE_W,
  localparam int BUS_W     = NUM_PLANES * PLANE_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrValid,
  input  logic [PLANE_W-1:0]    cpuByte,
  input  logic [1:0]            fbMode,
  input  logic                  srcIsCpu,
  input  logic [PLANE_W-1:0]    patternReg,
  input  logic [NUM_PLANES-1:0] fgColour,
  input  logic [NUM_PLANES-1:0] bgColour,
  input  logic                  maskEnable,
  input  logic                  maskFromCpu,
  input  logic [PLANE_W-1:0]    maskReg,
  input  logic [BUS_W-1:0]      fgLatch,
  input  logic [BUS_W-1:0]      readLatch,
  input  logic [BUS_W-1:0]      oldPlane,
  output logic                  outValid,
  output logic [BUS_W-1:0]      planeData,
  output logic [BUS_W-1:0]      planeBitEn
);
  ctrlStrobes_t       strobes;
  logic [PLANE_W-1:0] pattern;
  logic [PLANE_W-1:0] bitMask;

  pwf_ctrl #(.PLANE_W(PLANE_W)) u_ctrl (
    .wrValid     (wrValid),
    .fbMode      (fbMode),
    .srcIsCpu    (srcIsCpu),
    .cpuByte     (cpuByte),
    .patternReg  (patternReg),
    .maskEnable  (maskEnable),
    .maskFromCpu (maskFromCpu),
    .maskReg     (maskReg),
    .strobes     (strobes),
    .pattern     (pattern),
    .bitMask     (bitMask)
  );

  pwf_datapath #(.NUM_PLANES(NUM_PLANES), .PLANE_W(PLANE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cpuByte    (cpuByte),
    .pattern    (pattern),
    .bitMask    (bitMask),
    .fgColour   (fgColour),
    .bgColour   (bgColour),
    .fgLatch    (fgLatch),
    .readLatch  (readLatch),
    .oldPlane   (oldPlane),
    .outValid   (outValid),
    .planeData  (planeData),
    .planeBitEn (planeBitEn)
  );
endmodule

// File: tb/sim_colour_expand_wr.sv
`timescale 1ns/1ps
module sim_colour_expand_wr;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [7:0]  cpuByte = '0;
  logic [1:0]  fbMode = '0;
  logic        srcIsCpu = 1'b0;
  logic [7:0]  patternReg = '0;
  logic [3:0]  fgColour = '0;
  logic [3:0]  bgColour = '0;
  logic        maskEnable = 1'b0;
  logic        maskFromCpu = 1'b0;
  logic [7:0]  maskReg = '0;
  logic [31:0] fgLatch = '0;
  logic [31:0] readLatch = '0;
  logic [31:0] oldPlane = '0;
  logic        outValid;
  logic [31:0] planeData;
  logic [31:0] planeBitEn;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] d;
    logic [31:0] e;
    string       tag;
  } expItem_t;
  expItem_t sbQ[$];
  logic [31:0] lastD = '0;
  logic [31:0] lastE = '0;

  always #2 clk = ~clk;

  colour_expand_wr u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .cpuByte(cpuByte), .fbMode(fbMode),
    .srcIsCpu(srcIsCpu), .patternReg(patternReg), .fgColour(fgColour), .bgColour(bgColour),
    .maskEnable(maskEnable), .maskFromCpu(maskFromCpu), .maskReg(maskReg),
    .fgLatch(fgLatch), .readLatch(readLatch), .oldPlane(oldPlane),
    .outValid(outValid), .planeData(planeData), .planeBitEn(planeBitEn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected result built bit by bit from the requirement text
  task automatic model(output logic [31:0] d, output logic [31:0] e);
    for (int n = 0; n < 4; n++) begin
      for (int b = 0; b < 8; b++) begin
        logic nb, en, pat;
        pat = srcIsCpu ? cpuByte[b] : patternReg[b];
        case (fbMode)
          2'd0: nb = cpuByte[b];
          2'd1: nb = pat ? fgColour[n] : bgColour[n];
          2'd2: nb = fgLatch[8*n+b];
          default: nb = readLatch[8*n+b];
        endcase
        en = !maskEnable ? 1'b1 : (maskFromCpu ? cpuByte[b] : maskReg[b]);
        e[8*n+b] = en;
        d[8*n+b] = en ? nb : oldPlane[8*n+b];
      end
    end
  endtask

  // Driver: call at a negedge; applies one write for one cycle
  task automatic drive(input string tag);
    expItem_t it;
    wrValid = 1'b1;
    model(it.d, it.e);
    it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic setup(input logic [1:0] m, input logic s, input logic me, input logic mc);
    fbMode = m; srcIsCpu = s; maskEnable = me; maskFromCpu = mc;
  endtask

  // Monitor: compares every valid result against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && outValid) begin
        if (sbQ.size() == 0) begin
          check("R2 unexpected valid", 32'd1, 32'd0);
        end else begin
          expItem_t it;
          it = sbQ.pop_front();
          check({it.tag, " data"}, planeData, it.d);
          check({it.tag, " enable"}, planeBitEn, it.e);
          lastD = it.d; lastE = it.e;
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    fgLatch   = 32'hA5C3_3C5A;
    readLatch = 32'h1122_4488;
    oldPlane  = 32'hF0F0_0F0F;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, outValid}, 32'd0);
    check("R1 reset data", planeData, 32'd0);
    check("R1 reset enable", planeBitEn, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 data after release", planeData, 32'd0);
    check("R2 idle valid", {31'd0, outValid}, 32'd0);

    cpuByte = 8'h3C; setup(2'd0, 0, 0, 0);
    drive("R3 R8 passthrough");
    cpuByte = 8'hB2; fgColour = 4'b1010; bgColour = 4'b0110; setup(2'd1, 1, 0, 0);
    drive("R4 R5 solid cpu source");
    patternReg = 8'h0F; cpuByte = 8'hFF; setup(2'd1, 0, 0, 0);
    drive("R4 R5 solid pattern source");
    cpuByte = 8'h77; setup(2'd2, 0, 0, 0);
    drive("R6 dither");
    setup(2'd3, 0, 0, 0);
    drive("R7 background latch");
    maskReg = 8'h5A; cpuByte = 8'h81; setup(2'd0, 0, 1, 0);
    drive("R9 R10 mask register");
    cpuByte = 8'hC3; patternReg = 8'h96; setup(2'd1, 0, 1, 1);
    drive("R9 R10 mask from cpu");
    maskReg = 8'h00; setup(2'd3, 0, 1, 0);
    drive("R10 empty mask");
    repeat (2) @(negedge clk);

    // R11: inputs move without a strobe; outputs must not
    for (int i = 0; i < 3; i++) begin
      cpuByte = cpuByte ^ 8'hFF; fbMode = fbMode + 2'd1; maskEnable = ~maskEnable;
      oldPlane = ~oldPlane; fgLatch = fgLatch + 32'h0101_0101;
      @(negedge clk);
    end
    check("R11 hold data", planeData, lastD);
    check("R11 hold enable", planeBitEn, lastE);
    check("R2 no valid while idle", {31'd0, outValid}, 32'd0);

    // Back-to-back mixed writes
    for (int i = 0; i < 60; i++) begin
      cpuByte = 8'($urandom); patternReg = 8'($urandom); maskReg = 8'($urandom);
      fgColour = 4'($urandom); bgColour = 4'($urandom);
      fgLatch = $urandom; readLatch = $urandom; oldPlane = $urandom;
      setup(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      drive("R2 R3 R4 R5 R6 R7 R9 R10 mixed");
    end
    repeat (3) @(negedge clk);
    check("R2 all results seen", sbQ.size(), 32'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule